// File: doc/BRIEF.md
# Indirect Attribute Register Access Through Command and Data Byte Ports

This block puts a banked file of 32-bit attribute registers behind a narrow byte interface that offers only two addresses. One address is the command port and the other is the data port. A byte written to the command port is sorted by its top three bits. It sets either a bank pointer or an attribute pointer, and other bytes are dropped. The data port then moves the selected 32-bit attribute one byte at a time, least significant byte first. It works through an internal holding register that keeps a snapshot of the attribute.

A read at byte position zero captures the attribute into the holding register and returns its low byte. The next three reads return the remaining bytes of that same snapshot. After the fourth byte the position wraps to zero, so the next read captures a fresh copy. Writes to the data port use the same byte position. They gather bytes into the holding register and store the full word when the fourth byte arrives. A read from the command port returns a status byte for debug and does not move the sequence.

The bus is synchronous. The host raises a one-cycle `bus_valid` together with the direction and port select. The block answers with a one-cycle `bus_ready` on the following cycle, and `bus_rdata` is registered in that same cycle. A new access may be issued on every cycle.

Top module: `ixr_access`

## Requirements
- R1: Every cycle with `bus_valid` high is followed, one cycle later, by exactly one cycle of `bus_ready` high. `bus_ready` is never high at any other time. On acknowledges of write accesses `bus_rdata` is 0x00.
- R2: A command-port write whose bits [7:5] are 000 loads bits [4:0] into the bank pointer and resets the byte position to 0.
- R3: A command-port write whose bits [7:5] are 111 loads bits [4:0] into the attribute pointer and resets the byte position to 0.
- R4: A command-port write whose bits [7:5] are any other value leaves both pointers and the byte position unchanged.
- R5: The two pointers are written independently and in either order. A pointer that is not written keeps its value for later data-port accesses.
- R6: Data-port reads return the selected attribute least significant byte first: byte k (bits 8k+7..8k) at position k. Bytes 1 to 3 come from the snapshot taken when byte 0 was read.
- R7: After byte 3 is read or written, the position wraps to 0. The next read takes a new snapshot, so it reflects any value stored since the last snapshot.
- R8: Data-port writes place the byte at the current position of the holding register. The write at position 3 stores {that byte, holding bits 23..0} into the selected attribute.
- R9: A command-port read returns {position[1:0], bank pointer[2:0], attribute pointer[2:0]} and changes neither the pointers nor the position.
- R10: When the bank pointer is not below NUM_BANKS, or the attribute pointer is not below NUM_ATTRS, data reads return 0x00 and data writes store nothing. The position still advances.
- R11: After reset `bus_ready` and `bus_rdata` are 0, both pointers are 0 and the position is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | One-cycle access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cmd | input | 1 | 1 = command port, 0 = data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered, valid with bus_ready |
| bus_ready | output | 1 | Acknowledge, one cycle after bus_valid |

## Verification
A wrong byte position shows on the very next data read as a byte from the wrong lane. It also shows at once in the top two bits of a command-port read. A pointer that is loaded wrongly, or dropped, appears in the status byte at the next command read. A stale or missing snapshot appears when the sequence wraps and a value stored since the last snapshot fails to come back. A write that lands when it should have been ignored surfaces when the aliased attribute is read back through a valid selection.

// File: rtl/ixr_pkg.sv
package ixr_pkg;
  localparam int PTR_W   = 5;
  localparam int ATTR_W  = 32;
  localparam int BYTES   = ATTR_W / 8;
  localparam int IDX_W   = $clog2(BYTES);

  typedef enum logic [2:0] {
    PFX_BANK = 3'b000,
    PFX_ATTR = 3'b111
  } cmd_pfx_e;

  typedef logic [PTR_W-1:0] ptr_t;
  typedef logic [IDX_W-1:0] idx_t;
endpackage

// File: rtl/ixr_cmd_decode.sv
module ixr_cmd_decode
  import ixr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_byte,
  output ptr_t       bank_ptr,
  output ptr_t       attr_ptr,
  output logic       restart
);
  logic hit_bank, hit_attr;

  assign hit_bank = cmd_wr && (cmd_byte[7:5] == PFX_BANK);
  assign hit_attr = cmd_wr && (cmd_byte[7:5] == PFX_ATTR);
  assign restart  = hit_bank || hit_attr;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_ptr <= '0;
      attr_ptr <= '0;
    end else begin
      if (hit_bank) bank_ptr <= cmd_byte[PTR_W-1:0];
      if (hit_attr) attr_ptr <= cmd_byte[PTR_W-1:0];
    end
  end
endmodule

// File: rtl/ixr_attr_store.sv
module ixr_attr_store
  import ixr_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [ATTR_W-1:0] wdata,
  output logic [ATTR_W-1:0] rdata
);
  logic [ATTR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/ixr_byte_seq.sv
module ixr_byte_seq
  import ixr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              in_range,
  input  logic [7:0]        wr_byte,
  input  logic [ATTR_W-1:0] attr_q,
  output idx_t              idx,
  output logic [7:0]        rd_byte,
  output logic              commit_we,
  output logic [ATTR_W-1:0] commit_val
);
  localparam idx_t LAST = idx_t'(BYTES - 1);

  logic [ATTR_W-1:0] hold;
  logic [ATTR_W-1:0] snap;
  logic [IDX_W+2:0]  lane;

  assign snap    = in_range ? attr_q : '0;
  assign lane    = {idx, 3'b000};
  assign rd_byte = (idx == '0) ? snap[7:0] : hold[lane +: 8];

  assign commit_we  = wr_req && !restart && (idx == LAST) && in_range;
  assign commit_val = {wr_byte, hold[ATTR_W-9:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      hold <= '0;
    end else if (restart) begin
      idx <= '0;
    end else if (rd_req) begin
      if (idx == '0) hold <= snap;
      idx <= idx + idx_t'(1);
    end else if (wr_req) begin
      hold[lane +: 8] <= wr_byte;
      idx <= idx + idx_t'(1);
    end
  end
endmodule

// File: rtl/ixr_access.sv
module ixr_access
  import ixr_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int NUM_ATTRS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_valid,
  input  logic       bus_write,
  input  logic       bus_cmd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_ready
);
  localparam int DEPTH  = NUM_BANKS * NUM_ATTRS;
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic cmd_wr, cmd_rd, dat_wr, dat_rd;
  ptr_t bank_ptr, reg_ptr;
  idx_t seq_idx;
  logic restart, in_range, commit_we;
  logic [ADDR_W-1:0] attr_addr;
  logic [ATTR_W-1:0] attr_q, commit_val;
  logic [7:0] rd_byte, status_byte;

  assign cmd_wr = bus_valid &&  bus_write &&  bus_cmd;
  assign cmd_rd = bus_valid && !bus_write &&  bus_cmd;
  assign dat_wr = bus_valid &&  bus_write && !bus_cmd;
  assign dat_rd = bus_valid && !bus_write && !bus_cmd;

  ixr_cmd_decode u_dec (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (cmd_wr),
    .cmd_byte (bus_wdata),
    .bank_ptr (bank_ptr),
    .attr_ptr (reg_ptr),
    .restart  (restart)
  );

  assign in_range  = (32'(bank_ptr) < NUM_BANKS) && (32'(reg_ptr) < NUM_ATTRS);
  assign attr_addr = ADDR_W'(32'(bank_ptr) * NUM_ATTRS + 32'(reg_ptr));

  ixr_attr_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (commit_we),
    .addr  (attr_addr),
    .wdata (commit_val),
    .rdata (attr_q)
  );

  ixr_byte_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .restart    (restart),
    .rd_req     (dat_rd),
    .wr_req     (dat_wr),
    .in_range   (in_range),
    .wr_byte    (bus_wdata),
    .attr_q     (attr_q),
    .idx        (seq_idx),
    .rd_byte    (rd_byte),
    .commit_we  (commit_we),
    .commit_val (commit_val)
  );

  assign status_byte = {seq_idx, bank_ptr[2:0], reg_ptr[2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_valid;
      if (cmd_rd)      bus_rdata <= status_byte;
      else if (dat_rd) bus_rdata <= rd_byte;
      else             bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/ixr_access_chk.sv
module ixr_access_chk
  import ixr_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bus_valid,
  input logic       bus_write,
  input logic       bus_cmd,
  input logic [7:0] bus_wdata,
  input logic       bus_ready,
  input ptr_t       bank_ptr,
  input ptr_t       reg_ptr,
  input idx_t       seq_idx
);
  logic cmd_w, bank_w, attr_w, junk_w, cmd_r, dat_x;
  assign cmd_w  = bus_valid && bus_write && bus_cmd;
  assign bank_w = cmd_w && (bus_wdata[7:5] == 3'b000);
  assign attr_w = cmd_w && (bus_wdata[7:5] == 3'b111);
  assign junk_w = cmd_w && !bank_w && !attr_w;
  assign cmd_r  = bus_valid && !bus_write && bus_cmd;
  assign dat_x  = bus_valid && !bus_cmd;

  a_r1_ready_follows: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> bus_ready);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !bus_ready);
  a_r2_bank_load: assert property (@(posedge clk) disable iff (rst)
    bank_w |=> (bank_ptr == $past(bus_wdata[4:0])) && (seq_idx == '0) && $stable(reg_ptr));
  a_r3_attr_load: assert property (@(posedge clk) disable iff (rst)
    attr_w |=> (reg_ptr == $past(bus_wdata[4:0])) && (seq_idx == '0) && $stable(bank_ptr));
  a_r4_junk_ignored: assert property (@(posedge clk) disable iff (rst)
    junk_w |=> $stable(bank_ptr) && $stable(reg_ptr) && $stable(seq_idx));
  a_r9_status_quiet: assert property (@(posedge clk) disable iff (rst)
    cmd_r |=> $stable(bank_ptr) && $stable(reg_ptr) && $stable(seq_idx));
  a_r7_idx_steps: assert property (@(posedge clk) disable iff (rst)
    dat_x |=> (seq_idx == $past(seq_idx) + idx_t'(1)) && $stable(bank_ptr) && $stable(reg_ptr));
endmodule

bind ixr_access ixr_access_chk u_chk (.*);

// File: tb/tb_ixr_access.sv
`timescale 1ns/100ps
module tb_ixr_access;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_valid = 1'b0;
  logic       bus_write = 1'b0;
  logic       bus_cmd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_ready;

  int checks = 0;
  int errors = 0;
  bit         q_chk [$];
  logic [7:0] q_exp [$];
  string      q_tag [$];

  always #2.5 clk = ~clk;

  ixr_access dut (.*);

  task automatic note(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // driver: one access per cycle, starting at a falling edge
  task automatic access(input logic wr, input logic cmd, input logic [7:0] wd,
                        input bit chk, input logic [7:0] exp, input string tag);
    bus_valid = 1'b1; bus_write = wr; bus_cmd = cmd; bus_wdata = wd;
    q_chk.push_back(chk); q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_cmd = 1'b0; bus_wdata = '0;
  endtask

  task automatic cmd_w(input logic [7:0] b, input string tag);
    access(1'b1, 1'b1, b, 1'b0, 8'h00, tag);
  endtask
  task automatic dat_w(input logic [7:0] b, input string tag);
    access(1'b1, 1'b0, b, 1'b0, 8'h00, tag);
  endtask
  task automatic dat_r(input logic [7:0] e, input string tag);
    access(1'b0, 1'b0, 8'h00, 1'b1, e, tag);
  endtask
  task automatic cmd_r(input logic [7:0] e, input string tag);
    access(1'b0, 1'b1, 8'h00, 1'b1, e, tag);
  endtask

  // monitor: pops expectations as acknowledges appear
  always @(negedge clk) begin
    if (!rst && bus_ready) begin
      if (q_chk.size() == 0) begin
        note(1'b0, "R1 spurious ready", {7'd0, bus_ready}, 8'h00);
      end else begin
        bit c; logic [7:0] e; string t;
        c = q_chk.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
        if (c) note(bus_rdata === e, t, bus_rdata, e);
        else   note(bus_rdata === 8'h00, {"R1 write ack ", t}, bus_rdata, 8'h00);
      end
    end
  end

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    note(bus_ready === 1'b0, "R11 ready in reset", {7'd0, bus_ready}, 8'h00);
    note(bus_rdata === 8'h00, "R11 rdata in reset", bus_rdata, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    note(bus_ready === 1'b0, "R11 ready after reset", {7'd0, bus_ready}, 8'h00);

    cmd_r(8'h00, "R11 status after reset");
    // select bank 1 then attribute 2
    cmd_w(8'h01, "R2 bank=1");
    cmd_w(8'hE2, "R3 attr=2");
    cmd_r(8'h0A, "R9 status bank1 attr2 pos0");
    dat_w(8'h11, "R8 byte0");
    dat_w(8'h22, "R8 byte1");
    cmd_r(8'h8A, "R9 status pos2");
    dat_w(8'h33, "R8 byte2");
    dat_w(8'h44, "R8 byte3");
    dat_r(8'h11, "R6 byte0");
    dat_r(8'h22, "R6 byte1");
    dat_r(8'h33, "R6 byte2");
    dat_r(8'h44, "R6 byte3");
    dat_r(8'h11, "R7 wrap to byte0");
    cmd_r(8'h4A, "R9 status pos1");
    cmd_w(8'h55, "R4 junk command");
    cmd_w(8'hA3, "R4 junk command 2");
    cmd_r(8'h4A, "R4 pointers and pos kept");
    dat_r(8'h22, "R4 sequence continues");
    // bank 2, attribute pointer left at 2
    cmd_w(8'h02, "R5 bank=2 only");
    cmd_r(8'h12, "R5 attr pointer kept");
    dat_w(8'hAA, "R8 b2 byte0");
    dat_w(8'hBB, "R8 b2 byte1");
    dat_w(8'hCC, "R8 b2 byte2");
    dat_w(8'hDD, "R8 b2 byte3");
    dat_r(8'hAA, "R5 bank2 attr2 byte0");
    cmd_w(8'h01, "R2 back to bank1");
    dat_r(8'h11, "R2 restart byte0 bank1");
    dat_r(8'h22, "R5 bank1 attr2 byte1");
    // fresh snapshot after wrap
    cmd_w(8'hE2, "R3 restart");
    dat_r(8'h11, "R6 full pass byte0");
    dat_r(8'h22, "R6 full pass byte1");
    dat_r(8'h33, "R6 full pass byte2");
    dat_r(8'h44, "R6 full pass byte3");
    dat_w(8'h04, "R8 new byte0");
    dat_w(8'h03, "R8 new byte1");
    dat_w(8'h02, "R8 new byte2");
    dat_w(8'h01, "R8 new byte3");
    dat_r(8'h04, "R7 fresh snapshot byte0");
    dat_r(8'h03, "R7 fresh snapshot byte1");
    // out of range bank 5 aliases the bank1/attr2 word if not gated
    cmd_w(8'h05, "R10 bank=5");
    dat_r(8'h00, "R10 read zero byte0");
    dat_r(8'h00, "R10 read zero byte1");
    dat_r(8'h00, "R10 read zero byte2");
    dat_r(8'h00, "R10 read zero byte3");
    dat_w(8'hFF, "R10 ignored byte0");
    dat_w(8'hFF, "R10 ignored byte1");
    dat_w(8'hFF, "R10 ignored byte2");
    dat_w(8'hFF, "R10 ignored byte3");
    dat_r(8'h00, "R10 still zero");
    cmd_w(8'h00, "R2 bank=0");
    cmd_w(8'hFF, "R3 attr=31");
    dat_r(8'h00, "R10 attr out of range");
    cmd_w(8'h01, "R2 bank=1");
    cmd_w(8'hE2, "R3 attr=2");
    dat_r(8'h04, "R10 target untouched byte0");
    dat_r(8'h03, "R10 target untouched byte1");
    dat_r(8'h02, "R10 target untouched byte2");
    dat_r(8'h01, "R10 target untouched byte3");

    repeat (4) @(negedge clk);
    note(q_chk.size() == 0, "R1 every access acknowledged", 8'(q_chk.size()), 8'h00);
    finish_run();
  end
endmodule